// File: doc/BRIEF.md
# SPI Controller Interrupt Register Bank

This block holds the interrupt state of an SPI master controller: a status register that captures events reported by the transfer engine, a mask register that selects which events may raise the interrupt, and a transmit watermark setting. It drives one registered interrupt line. Software reaches the state through a plain register port. Each write is a single-cycle strobe with an address and data. Reads return data combinationally for the address that is presented.

The mask has no direct write path. Ones written to the enable offset set mask bits, ones written to the disable offset clear them, and the result is read back at a separate read-only offset. Status bits are cleared by writing ones to the status offset. Writing back a value just read therefore acknowledges exactly the events that were seen. The receive-data-available event is a level: its status bit follows the input one cycle later and cannot be cleared while data remains. The register port is control traffic, not a data stream, so it carries no valid/ready handshake. A write is always accepted in the cycle it is strobed.

Top module: `spi_irq_bank`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0, the mask register (offset 0x10) reads 0, the interrupt output is 0 and the watermark register (offset 0x28) reads 1.
- R2: An edge-type event input held high for one cycle sets its status bit at the next clock edge, and the bit stays set after the input drops. Bit 1 is mode fault, bit 2 is transmit below watermark, bit 3 is transmit full, and bits 0, 5 and 6 are spare edge events.
- R3: A write to offset 0x04 clears every edge-type status bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R4: When an event input is high in the same cycle as a clearing write to that bit, the bit ends up set.
- R5: A write to offset 0x08 sets every mask bit whose data bit is 1 and leaves the others unchanged. The mask reads back at offset 0x10.
- R6: A write to offset 0x0C clears every mask bit whose data bit is 1 and leaves the others unchanged.
- R7: Status bit 4 (receive data available) equals its event input as sampled at the previous clock edge. Writing 1 to it has no effect while the input stays high.
- R8: The interrupt output rises one clock after any bit is set in both status and mask, and falls one clock after no bit is set in both.
- R9: The watermark register at offset 0x28 is read/write, holds the low 8 bits of the written data, and ignores the other data bits.
- R10: Reads of offsets 0x08, 0x0C and unmapped offsets return 0. Writes to 0x10 or to unmapped offsets change neither status, mask nor watermark. Status and mask bits above bit 6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_in | input | 7 | Event inputs from the transfer engine, one per status bit |
| wmark | output | 8 | Current transmit watermark setting |
| irq | output | 1 | Registered interrupt request |

## Verification
The status path is driven with single-bit pulses and with several bits at once. Clears are then written with partial patterns, so a clear that touches too many bits shows up apart from one that touches too few. An event is made to coincide with a clearing write to separate set-priority from clear-priority. The level bit is held high across a clearing write and then released, which tells a level bit from a latched one. Enable and disable writes use overlapping patterns, and the interrupt is sampled on the cycle the status bit appears and on the cycle after, which shows the single register stage.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int IRQ_W = 7;
  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_ENABLE = 8'h08;
  localparam logic [7:0] OFS_DISABLE = 8'h0C;
  localparam logic [7:0] OFS_MASK = 8'h10;
  localparam logic [7:0] OFS_WMARK = 8'h28;

  localparam int BIT_MODE_FAULT = 1;
  localparam int BIT_TX_LOW = 2;
  localparam int BIT_TX_FULL = 3;
  localparam int BIT_RX_AVAIL = 4;

  typedef struct packed {
    logic stat_clr;
    logic mask_set;
    logic mask_clr;
    logic wm_load;
  } wr_strobe_t;
endpackage

// File: rtl/spi_irq_cell.sv
module spi_irq_cell #(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic clr,
  output logic stat
);
  generate
    if (IS_LEVEL) begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n) stat <= 1'b0;
        else        stat <= ev;
      end
      // R7: bit follows the level sampled one edge earlier
      a_r7_level_high: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> stat);
      a_r7_level_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> !stat);
    end else begin : g_edge
      always_ff @(posedge clk) begin
        if (!rst_n) stat <= 1'b0;
        else        stat <= ev | (stat & ~clr);
      end
      a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> stat);
      a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev && clr) |=> !stat);
      a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !clr) |=> stat);
    end
  endgenerate
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int W = 7,
  parameter logic [W-1:0] LEVEL_BITS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] stat
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    spi_irq_cell #(.IS_LEVEL(LEVEL_BITS[i])) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .ev   (ev[i]),
      .clr  (clr_we & clr_bits[i]),
      .stat (stat[i])
    );
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  logic [W-1:0] set_v, clr_v;
  assign set_v = set_we ? bits : '0;
  assign clr_v = clr_we ? bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | set_v) & ~clr_v;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    a_r5_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && bits[i]) |=> mask[i]);
    a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && bits[i]) |=> !mask[i]);
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      !((set_we || clr_we) && bits[i]) |=> (mask[i] == $past(mask[i])));
  end
endmodule

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int W = 7,
  parameter int WM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      stat,
  input  logic [W-1:0]      mask,
  input  logic [WM_W-1:0]   wm,
  output wr_strobe_t        strb,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DISABLE);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_WM   = ADDR_W'(OFS_WMARK);

  always_comb begin
    strb.stat_clr = wr && (addr == A_STAT);
    strb.mask_set = wr && (addr == A_EN);
    strb.mask_clr = wr && (addr == A_DIS);
    strb.wm_load  = wr && (addr == A_WM);
  end

  always_comb begin
    unique case (addr)
      A_STAT:  rdata = DATA_W'(stat);
      A_MASK:  rdata = DATA_W'(mask);
      A_WM:    rdata = DATA_W'(wm);
      default: rdata = '0;
    endcase
  end

  // R10: a write reaches at most one register
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
  a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |-> (strb == '0));
endmodule

// File: rtl/spi_irq_bank.sv
module spi_irq_bank
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_EV = IRQ_W,
  parameter logic [NUM_EV-1:0] LEVEL_BITS = NUM_EV'(1) << BIT_RX_AVAIL,
  parameter int WM_W = 8,
  parameter logic [WM_W-1:0] WM_RESET = WM_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EV-1:0] ev_in,
  output logic [WM_W-1:0]   wmark,
  output logic              irq
);
  wr_strobe_t        strb;
  logic [NUM_EV-1:0] stat, mask;
  logic [NUM_EV-1:0] wbits;
  logic              pending;

  assign wbits = reg_wdata[NUM_EV-1:0];

  spi_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(NUM_EV), .WM_W(WM_W)) u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (reg_wr),
    .addr (reg_addr),
    .stat (stat),
    .mask (mask),
    .wm   (wmark),
    .strb (strb),
    .rdata(reg_rdata)
  );

  spi_irq_status #(.W(NUM_EV), .LEVEL_BITS(LEVEL_BITS)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_in),
    .clr_we  (strb.stat_clr),
    .clr_bits(wbits),
    .stat    (stat)
  );

  spi_irq_mask #(.W(NUM_EV)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .set_we(strb.mask_set),
    .clr_we(strb.mask_clr),
    .bits  (wbits),
    .mask  (mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            wmark <= WM_RESET;
    else if (strb.wm_load) wmark <= reg_wdata[WM_W-1:0];
  end

  assign pending = |(stat & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending;
  end

  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> irq);
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !irq);
  a_r9_wm_load: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wm_load |=> (wmark == $past(reg_wdata[WM_W-1:0])));
  a_r10_wm_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wm_load |=> $stable(wmark));
endmodule

// File: tb/tb_spi_irq_bank.sv
module tb_spi_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  ev_in = '0;
  logic [7:0]  wmark;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  spi_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in),
    .wmark(wmark), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk);
    ev_in = v;
    @(negedge clk);
    ev_in = '0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    ev_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    do_reset();
    rd(8'h04, d); chk("R1 status", d, 32'h0);
    rd(8'h10, d); chk("R1 mask", d, 32'h0);
    rd(8'h28, d); chk("R1 wmark", d, 32'h1);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    do_reset();
    pulse(7'h02);
    rd(8'h04, d); chk("R2 mode fault latched", d, 32'h02);
    @(negedge clk);
    rd(8'h04, d); chk("R2 held", d, 32'h02);
    pulse(7'h69);
    rd(8'h04, d); chk("R2 multi", d, 32'h6B);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    do_reset();
    pulse(7'h6E);
    wr(8'h04, 32'h0000_0024);
    rd(8'h04, d); chk("R3 partial clear", d, 32'h4A);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R3 clear all", d, 32'h00);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    do_reset();
    pulse(7'h08);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h0A; ev_in = 7'h02;
    @(negedge clk);
    reg_wr = 1'b0; ev_in = '0;
    rd(8'h04, d); chk("R4 set wins over clear", d, 32'h02);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    do_reset();
    wr(8'h08, 32'h0000_0016);
    rd(8'h10, d); chk("R5 enable sets", d, 32'h16);
    wr(8'h08, 32'h0000_0041);
    rd(8'h10, d); chk("R5 zeros keep", d, 32'h57);
    wr(8'h0C, 32'h0000_0014);
    rd(8'h10, d); chk("R6 disable clears", d, 32'h43);
    rd(8'h08, d); chk("R10 enable reads zero", d, 32'h0);
    rd(8'h0C, d); chk("R10 disable reads zero", d, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    do_reset();
    @(negedge clk); ev_in = 7'h10;
    @(negedge clk);
    rd(8'h04, d); chk("R7 level follows", d, 32'h10);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h10;
    @(negedge clk); reg_wr = 1'b0;
    rd(8'h04, d); chk("R7 clear ignored while high", d, 32'h10);
    ev_in = '0;
    @(negedge clk);
    rd(8'h04, d); chk("R7 drops with level", d, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    do_reset();
    wr(8'h08, 32'h08);
    pulse(7'h04);
    chk("R8 unmasked no irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 unmasked still no irq", {31'b0, irq}, 32'h0);
    pulse(7'h08);
    chk("R8 irq one cycle late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h08);
    chk("R8 irq lags clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);
    rd(8'h04, d); chk("R8 other status kept", d, 32'h04);
    wr(8'h08, 32'h04);
    @(negedge clk);
    chk("R8 irq on mask enable", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_wmark;
    logic [31:0] d;
    do_reset();
    wr(8'h28, 32'hABCD_1240);
    rd(8'h28, d); chk("R9 wmark write", d, 32'h40);
    chk("R9 wmark port", {24'b0, wmark}, 32'h40);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    do_reset();
    pulse(7'h02);
    wr(8'h08, 32'h02);
    wr(8'h10, 32'h7F);
    wr(8'h14, 32'hFF);
    wr(8'h00, 32'hFF);
    rd(8'h10, d); chk("R10 mask unchanged", d, 32'h02);
    rd(8'h04, d); chk("R10 status unchanged", d, 32'h02);
    rd(8'h28, d); chk("R10 wmark unchanged", d, 32'h01);
    rd(8'h20, d); chk("R10 unmapped reads zero", d, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latch();
        t_clear();
        t_set_wins();
        t_mask();
        t_level();
        t_irq();
        t_wmark();
        t_ignore();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule